// File: doc/BRIEF.md
# UART Operation-Mode Register with Power Gating

This block holds the 8-bit operation-mode word of an asynchronous serial port and turns its top bit into a master power switch for the rest of the port. The bus can load the whole byte or set or clear one bit at a time. The decoded fields drive the transmitter and receiver: transmit enable, receive enable, parity selection, character length, stop-bit length and error-interrupt enable.

The power bit controls the port's internal operation clock. While the bit is low, the clock is held low and the shift logic is held in reset. The serial output is forced to the idle (high) level, and the receiver sees an idle (high) line. When the bit falls, the status registers and the receive buffer get a one-cycle clear pulse. When the bit rises, the operation clock stays quiet for one full base-clock cycle and then starts without a runt pulse. The enable for the clock gate changes only while the base clock is low.

Rewriting the register with the value it already holds leaves a running transfer untouched.

Top module: `uart_mode_ctrl`

## Requirements
- R1: On synchronous reset the register holds 0x01. This means power, transmit enable, receive enable, parity, character length and stop length are all 0, and the error-interrupt enable is 1.
- R2: A byte write loads all 8 bits in one edge. The bit layout is: bit 7 power, bit 6 transmit enable, bit 5 receive enable, bits 4:3 parity select, bit 2 character length, bit 1 stop length, bit 0 error-interrupt enable.
- R3: A single-bit write sets bit `wr_bit_sel` to `wr_bit_val` and leaves the other seven bits unchanged.
- R4: When a byte write and a single-bit write arrive in the same cycle, the byte write wins.
- R5: While the power bit is 0, `op_clk` stays low and produces no rising edge.
- R6: Suppose the power bit goes from 0 to 1 at base edge k. Then `op_clk` has no rising edge at k or at k+1, and its first rising edge coincides with base edge k+2.
- R7: While the power bit is 0, `txd_pin` is 1, including when power is removed while `txd_core` is low. While the power bit is 1, `txd_pin` follows `txd_core`.
- R8: While the power bit is 1, `rxd_int` follows `rxd_pin` through a synchronizer of SYNC_STAGES flops (2 by default). While the power bit is 0, `rxd_int` is 1.
- R9: `stat_clr` is 1 throughout reset. After reset it is 1 for exactly one cycle following a 1-to-0 change of the power bit, and 0 otherwise.
- R10: `core_rst` is 1 whenever reset is asserted or the power bit is 0, and 0 otherwise.
- R11: A byte write of the current value while power and transmit/receive are enabled changes no field, raises no `stat_clr` and leaves `op_clk` pulsing once per base cycle without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock of the serial port |
| rst | input | 1 | Synchronous active-high reset |
| wr_byte_en | input | 1 | Load the whole register from wr_byte_data |
| wr_byte_data | input | 8 | Byte write data |
| wr_bit_en | input | 1 | Single-bit write strobe |
| wr_bit_sel | input | 3 | Index of the bit to write |
| wr_bit_val | input | 1 | Value for the selected bit |
| rxd_pin | input | 1 | Raw serial receive line |
| txd_core | input | 1 | Serial data from the transmit shifter |
| op_clk | output | 1 | Gated operation clock |
| core_rst | output | 1 | Reset for the shift engines |
| tx_en | output | 1 | Transmit enable field |
| rx_en | output | 1 | Receive enable field |
| parity_sel | output | 2 | Parity select field |
| char_len | output | 1 | Character length field |
| stop_len | output | 1 | Stop-bit length field |
| err_irq_en | output | 1 | Error-interrupt enable field |
| rxd_int | output | 1 | Synchronized, power-forced receive line |
| txd_pin | output | 1 | Serial output, forced high while powered down |
| stat_clr | output | 1 | Clear pulse for status and receive buffer |

## Verification
The hardest case to reach is a power-down in the middle of a frame. In that case the shifter is driving a low bit, the receive line is low and the gated clock is running, all at once. The stimulus sets up exactly that state: it powers the port, holds `txd_core` and `rxd_pin` low, and then clears bit 7 with a single-bit write. The bench then checks that both lines return high, that the clear pulse lasts exactly one cycle and that the clock stops. The start delay is measured by counting `op_clk` rising edges at each falling edge of the base clock after the power bit is written.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;

    localparam int MODE_W = 8;
    localparam int IDX_W  = $clog2(MODE_W);

    // bit 7 power, 6 tx, 5 rx, 4:3 parity, 2 length, 1 stop, 0 irq
    typedef struct packed {
        logic       power;
        logic       tx_en;
        logic       rx_en;
        logic [1:0] parity;
        logic       char_len;
        logic       stop_len;
        logic       err_irq_en;
    } mode_t;

    localparam logic [MODE_W-1:0] MODE_RESET = 8'h01;

    function automatic mode_t write_one_bit(mode_t cur, logic [IDX_W-1:0] idx, logic val);
        logic [MODE_W-1:0] v;
        v = cur;
        v[idx] = val;
        return mode_t'(v);
    endfunction

endpackage

// File: rtl/umr_regfile.sv
module umr_regfile
    import uart_mode_pkg::*;
#(
    parameter logic [MODE_W-1:0] RST_VAL = MODE_RESET
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_en,
    input  logic [MODE_W-1:0] byte_data,
    input  logic             bit_en,
    input  logic [IDX_W-1:0] bit_sel,
    input  logic             bit_val,
    output mode_t            mode
);

    mode_t mode_r;
    mode_t mode_nxt;

    always_comb begin
        mode_nxt = mode_r;
        if (byte_en) begin
            mode_nxt = mode_t'(byte_data);
        end else if (bit_en) begin
            mode_nxt = write_one_bit(mode_r, bit_sel, bit_val);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r <= mode_t'(RST_VAL);
        end else begin
            mode_r <= mode_nxt;
        end
    end

    assign mode = mode_r;

endmodule

// File: rtl/umr_power_seq.sv
module umr_power_seq (
    input  logic clk,
    input  logic rst,
    input  logic power,
    output logic gate_en,
    output logic op_clk,
    output logic core_rst,
    output logic stat_clr
);

    logic pwr_d1;
    logic pwr_prev;
    logic en_n;

    // pwr_d1 supplies the one-cycle start delay; pwr_prev is used to see the falling edge
    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_d1   <= 1'b0;
            pwr_prev <= 1'b0;
        end else begin
            pwr_d1   <= power;
            pwr_prev <= power;
        end
    end

    // gate enable changes only while clk is low: no runt pulses
    always_ff @(negedge clk) begin
        if (rst) begin
            en_n <= 1'b0;
        end else begin
            en_n <= power & pwr_d1;
        end
    end

    assign gate_en  = en_n;
    assign op_clk   = clk & en_n;
    assign core_rst = rst | ~power;
    assign stat_clr = rst | (pwr_prev & ~power);

endmodule

// File: rtl/umr_pin_force.sv
module umr_pin_force #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic power,
    input  logic rxd_pin,
    input  logic txd_core,
    output logic rxd_int,
    output logic txd_pin
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        logic d_in;
        if (s == 0) begin : g_first
            assign d_in = rxd_pin;
        end else begin : g_next
            assign d_in = sync_q[s-1];
        end
        always_ff @(posedge clk) begin
            if (rst || !power) begin
                sync_q[s] <= 1'b1;
            end else begin
                sync_q[s] <= d_in;
            end
        end
    end

    assign rxd_int = power ? sync_q[LAST] : 1'b1;
    assign txd_pin = power ? txd_core : 1'b1;

endmodule

// File: rtl/uart_mode_ctrl.sv
module uart_mode_ctrl
    import uart_mode_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [MODE_W-1:0] RST_VAL     = MODE_RESET
) (
    input  logic       clk_base,
    input  logic       rst,
    input  logic       wr_byte_en,
    input  logic [7:0] wr_byte_data,
    input  logic       wr_bit_en,
    input  logic [2:0] wr_bit_sel,
    input  logic       wr_bit_val,
    input  logic       rxd_pin,
    input  logic       txd_core,
    output logic       op_clk,
    output logic       core_rst,
    output logic       tx_en,
    output logic       rx_en,
    output logic [1:0] parity_sel,
    output logic       char_len,
    output logic       stop_len,
    output logic       err_irq_en,
    output logic       rxd_int,
    output logic       txd_pin,
    output logic       stat_clr
);

    mode_t mode_q;
    logic  gate_en;

    umr_regfile #(.RST_VAL(RST_VAL)) u_reg (
        .clk       (clk_base),
        .rst       (rst),
        .byte_en   (wr_byte_en),
        .byte_data (wr_byte_data),
        .bit_en    (wr_bit_en),
        .bit_sel   (wr_bit_sel),
        .bit_val   (wr_bit_val),
        .mode      (mode_q)
    );

    umr_power_seq u_pwr (
        .clk      (clk_base),
        .rst      (rst),
        .power    (mode_q.power),
        .gate_en  (gate_en),
        .op_clk   (op_clk),
        .core_rst (core_rst),
        .stat_clr (stat_clr)
    );

    umr_pin_force #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk      (clk_base),
        .rst      (rst),
        .power    (mode_q.power),
        .rxd_pin  (rxd_pin),
        .txd_core (txd_core),
        .rxd_int  (rxd_int),
        .txd_pin  (txd_pin)
    );

    assign tx_en      = mode_q.tx_en;
    assign rx_en      = mode_q.rx_en;
    assign parity_sel = mode_q.parity;
    assign char_len   = mode_q.char_len;
    assign stop_len   = mode_q.stop_len;
    assign err_irq_en = mode_q.err_irq_en;

endmodule

// File: rtl/umr_chk.sv
module umr_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] mode_q,
    input logic       gate_en,
    input logic       wr_byte_en,
    input logic [7:0] wr_byte_data,
    input logic       wr_bit_en,
    input logic [2:0] wr_bit_sel,
    input logic       wr_bit_val,
    input logic       core_rst,
    input logic       txd_pin,
    input logic       rxd_int,
    input logic       stat_clr
);

    // R1
    reset_value_chk: assert property (@(posedge clk) rst |=> (mode_q == 8'h01));

    // R2
    byte_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_byte_en |=> (mode_q == $past(wr_byte_data)));

    // R3
    bit_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_bit_en && !wr_byte_en) |=> (mode_q[$past(wr_bit_sel)] == $past(wr_bit_val)));

    // R5
    gate_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_q[7] && !$past(mode_q[7])) |-> !gate_en);

    // R6
    start_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_q[7]) |-> !gate_en);

    // R6
    start_go_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mode_q[7]) ##1 mode_q[7]) |-> gate_en);

    // R7
    txd_idle_chk: assert property (@(posedge clk) core_rst |-> txd_pin);

    // R8
    rxd_idle_chk: assert property (@(posedge clk) core_rst |-> rxd_int);

    // R9
    clr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_q[7]) |-> stat_clr);

    // R9
    clr_single_chk: assert property (@(posedge clk) disable iff (rst)
        stat_clr |=> !stat_clr);

endmodule

bind uart_mode_ctrl umr_chk u_chk (
    .clk          (clk_base),
    .rst          (rst),
    .mode_q       (mode_q),
    .gate_en      (gate_en),
    .wr_byte_en   (wr_byte_en),
    .wr_byte_data (wr_byte_data),
    .wr_bit_en    (wr_bit_en),
    .wr_bit_sel   (wr_bit_sel),
    .wr_bit_val   (wr_bit_val),
    .core_rst     (core_rst),
    .txd_pin      (txd_pin),
    .rxd_int      (rxd_int),
    .stat_clr     (stat_clr)
);

// File: tb/sim_uart_mode_ctrl.sv
module sim_uart_mode_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk_base = 1'b0;
    logic       rst = 1'b1;
    logic       wr_byte_en = 1'b0;
    logic [7:0] wr_byte_data = 8'h00;
    logic       wr_bit_en = 1'b0;
    logic [2:0] wr_bit_sel = 3'd0;
    logic       wr_bit_val = 1'b0;
    logic       rxd_pin = 1'b1;
    logic       txd_core = 1'b1;
    logic       op_clk, core_rst, tx_en, rx_en, char_len, stop_len, err_irq_en;
    logic       rxd_int, txd_pin, stat_clr;
    logic [1:0] parity_sel;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;

    uart_mode_ctrl u0 (
        .clk_base(clk_base), .rst(rst),
        .wr_byte_en(wr_byte_en), .wr_byte_data(wr_byte_data),
        .wr_bit_en(wr_bit_en), .wr_bit_sel(wr_bit_sel), .wr_bit_val(wr_bit_val),
        .rxd_pin(rxd_pin), .txd_core(txd_core),
        .op_clk(op_clk), .core_rst(core_rst), .tx_en(tx_en), .rx_en(rx_en),
        .parity_sel(parity_sel), .char_len(char_len), .stop_len(stop_len),
        .err_irq_en(err_irq_en), .rxd_int(rxd_int), .txd_pin(txd_pin),
        .stat_clr(stat_clr)
    );

    always #(CLK_PERIOD/2) clk_base = ~clk_base;
    always @(posedge op_clk) edges <= edges + 1;

    function automatic logic [7:0] fields();
        return {1'b0, tx_en, rx_en, parity_sel, char_len, stop_len, err_irq_en};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(logic [7:0] v);
        @(negedge clk_base);
        wr_byte_en = 1'b1; wr_byte_data = v;
        @(negedge clk_base);
        wr_byte_en = 1'b0;
    endtask

    task automatic write_bit(logic [2:0] i, logic v);
        @(negedge clk_base);
        wr_bit_en = 1'b1; wr_bit_sel = i; wr_bit_val = v;
        @(negedge clk_base);
        wr_bit_en = 1'b0;
    endtask

    task automatic t_reset();
        int e0;
        rst = 1'b1;
        repeat (3) @(negedge clk_base);
        e0 = edges;
        check("R9 clr during reset", stat_clr, 1);
        check("R10 core_rst in reset", core_rst, 1);
        rst = 1'b0;
        @(negedge clk_base);
        check("R1 reset fields", fields(), 8'h01);
        check("R5 no op_clk after reset", edges, e0);
        check("R7 txd idle", txd_pin, 1);
        check("R9 clr released", stat_clr, 0);
    endtask

    task automatic t_byte();
        int e0;
        e0 = edges;
        write_byte(8'h5A);
        check("R2 byte 0x5A", fields(), 8'h5A);
        check("R2 parity field", parity_sel, 2'b11);
        repeat (3) @(negedge clk_base);
        check("R5 still gated", edges, e0);
        check("R10 core_rst unpowered", core_rst, 1);
    endtask

    task automatic t_bits();
        write_bit(3'd5, 1'b1);
        check("R3 set bit5", fields(), 8'h7A);
        write_bit(3'd1, 1'b0);
        check("R3 clear bit1", fields(), 8'h78);
    endtask

    task automatic t_priority();
        @(negedge clk_base);
        wr_byte_en = 1'b1; wr_byte_data = 8'h1C;
        wr_bit_en = 1'b1; wr_bit_sel = 3'd0; wr_bit_val = 1'b1;
        @(negedge clk_base);
        wr_byte_en = 1'b0; wr_bit_en = 1'b0;
        check("R4 byte wins", fields(), 8'h1C);
    endtask

    task automatic t_power_on();
        int e0;
        write_byte(8'hE1);
        e0 = edges;
        check("R6 no edge at write edge", edges, e0);
        check("R10 core_rst released", core_rst, 0);
        check("R9 no clr on power up", stat_clr, 0);
        @(negedge clk_base);
        check("R6 no edge one cycle later", edges, e0);
        @(negedge clk_base);
        check("R6 first edge", edges, e0 + 1);
        @(negedge clk_base);
        check("R6 running", edges, e0 + 2);
    endtask

    task automatic t_pins();
        txd_core = 1'b0; #1;
        check("R7 txd follows core low", txd_pin, 0);
        txd_core = 1'b1; #1;
        check("R7 txd follows core high", txd_pin, 1);
        @(negedge clk_base);
        rxd_pin = 1'b0;
        @(negedge clk_base);
        check("R8 sync stage one", rxd_int, 1);
        @(negedge clk_base);
        check("R8 sync stage two", rxd_int, 0);
        rxd_pin = 1'b1;
        repeat (2) @(negedge clk_base);
        check("R8 back high", rxd_int, 1);
    endtask

    task automatic t_rewrite();
        int e0;
        int clr_seen;
        clr_seen = 0;
        e0 = edges;
        write_byte(8'hE1);
        for (int i = 0; i < 4; i++) begin
            if (stat_clr) clr_seen++;
            @(negedge clk_base);
        end
        check("R11 no clr on rewrite", clr_seen, 0);
        check("R11 clock uninterrupted", edges, e0 + 6);
        check("R11 fields unchanged", fields(), 8'h61);
    endtask

    task automatic t_power_off();
        int e0;
        txd_core = 1'b0;
        rxd_pin = 1'b0;
        repeat (3) @(negedge clk_base);
        check("R7 mid-frame low", txd_pin, 0);
        check("R8 rx low before off", rxd_int, 0);
        write_bit(3'd7, 1'b0);
        e0 = edges;
        check("R7 txd forced high", txd_pin, 1);
        check("R8 rxd forced high", rxd_int, 1);
        check("R9 clr pulse", stat_clr, 1);
        check("R10 core_rst on power off", core_rst, 1);
        @(negedge clk_base);
        check("R9 clr one cycle", stat_clr, 0);
        repeat (3) @(negedge clk_base);
        check("R5 clock stopped", edges, e0);
        check("R7 txd still high", txd_pin, 1);
        txd_core = 1'b1;
        rxd_pin = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_byte();
        t_bits();
        t_priority();
        t_power_on();
        t_pins();
        t_rewrite();
        t_power_off();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule